// File: doc/BRIEF.md
# Reversible Block Cellular Automaton Engine

This block holds a square, toroidally wrapped lattice of binary cells and advances it by one step of a reversible block automaton per strobe. In each step, the lattice is tiled into 2x2 blocks and one fixed local rule is applied to every block at once. Blocks whose contents form exactly one diagonal pair have that pair moved to the other diagonal. Every other block is turned through 180 degrees. The tiling origin moves by one cell along both axes on every step. Because of this, information crosses block borders and particles travel along diagonals. When two particles collide, they are deflected in a way that can be reversed, so suitably placed particles act as logic gates.

The block rule undoes itself. A backward step therefore uses the same hardware: it first restores the previous tiling phase and then applies the rule with that phase. This recovers the preceding lattice exactly. A host loads an initial pattern, issues forward or backward steps, and reads every cell in parallel. A wrapping step counter rises on forward steps and falls on backward steps.

Top module: `mbca_lattice_engine`

## Requirements
- R1: While reset is held, the lattice is empty, the step count is 0 and the phase output is 0 (blocks start at even row and column).
- R2: A load pulse copies `load_pattern` into the lattice on the next clock edge and clears the count and the phase. A load has priority over a step strobe in the same cycle. Cell (row r, column c) sits at bit r*SIDE+c.
- R3: A block with no diagonal-pair pattern is rotated 180 degrees. Its top-left cell swaps with bottom-right, and top-right swaps with bottom-left. This includes a lone particle, three particles, or a full block.
- R4: A block holding only top-left and bottom-right becomes only top-right and bottom-left, and the reverse also holds.
- R5: A forward step uses the tiling given by the current phase and then toggles the phase. Phase 0 puts block origins at even coordinates and phase 1 at odd coordinates, with indices wrapping modulo SIDE.
- R6: Every step leaves the number of occupied cells unchanged.
- R7: The step count adds one on a forward step and subtracts one on a backward step, modulo 2^CNT_W.
- R8: A backward step restores the lattice, phase and count that existed before the matching forward step. N forward steps followed by N backward steps return the loaded pattern.
- R9: On a 10x10 lattice, load inputs A at (2,2) and B at (7,7) and take four forward steps. Cell (3,6) and cell (6,3) then hold A and B, cell (6,6) holds A and not B, and cell (3,3) holds not A and B.
- R10: Without a step strobe or load, the lattice, count and phase hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Load strobe for the initial pattern |
| load_pattern | input | SIDE*SIDE | Pattern to load, bit r*SIDE+c is cell (r,c) |
| step | input | 1 | Step strobe, one lattice step per cycle it is high |
| reverse | input | 1 | 0 selects a forward step, 1 selects a backward step |
| cells | output | SIDE*SIDE | Current lattice, bit r*SIDE+c is cell (r,c) |
| step_count | output | CNT_W | Net number of steps taken since load |
| phase | output | 1 | Tiling phase the next forward step will use |

## Verification
A wrong block mapping or a wrong partition offset is visible on `cells` one cycle after the offending step. In most cases it also shows up as a moved or vanished particle within the following one to four steps, long before the gate outputs are read. A phase register that fails to toggle causes a single particle to oscillate instead of travelling. It also breaks round-trip restoration, so a forward-then-backward run exposes it at the end of the backward run. A counter fault is visible on `step_count` on the very next cycle.

// File: rtl/mbca_pkg.sv
package mbca_pkg;

   // Block cell order: bit0 top-left, bit1 top-right, bit2 bottom-left, bit3 bottom-right
   typedef logic [3:0] quad_t;

   localparam quad_t DIAG_MAIN = 4'b1001;  // top-left + bottom-right
   localparam quad_t DIAG_ANTI = 4'b0110;  // top-right + bottom-left

   typedef enum logic {
      PH_EVEN = 1'b0,
      PH_ODD  = 1'b1
   } phase_e;

endpackage

// File: rtl/mbca_block_rule.sv
module mbca_block_rule
   import mbca_pkg::*;
(
   input  quad_t cur,
   output quad_t nxt
);

   logic is_main;
   logic is_anti;
   quad_t spun;

   assign is_main = (cur == DIAG_MAIN);
   assign is_anti = (cur == DIAG_ANTI);

   // half-turn: TL<->BR, TR<->BL
   assign spun = {cur[0], cur[1], cur[2], cur[3]};

   always_comb begin
      if (is_main)      nxt = DIAG_ANTI;
      else if (is_anti) nxt = DIAG_MAIN;
      else              nxt = spun;
   end

   // R6: one block never creates or destroys a particle
   always_comb begin
      if (!$isunknown(cur))
         a_r6_block_conserve: assert ($countones(nxt) == $countones(cur));
   end

endmodule

// File: rtl/mbca_lattice_step.sv
module mbca_lattice_step
   import mbca_pkg::*;
#(
   parameter int unsigned SIDE = 10
) (
   input  logic [SIDE*SIDE-1:0] cur,
   input  logic                 rule_phase,
   output logic [SIDE*SIDE-1:0] nxt
);

   localparam int unsigned CELLS = SIDE * SIDE;
   localparam int unsigned HALF  = SIDE / 2;

   logic [1:0][CELLS-1:0] cand;

   // Both tilings are built; the phase picks one.
   for (genvar p = 0; p < 2; p++) begin : g_phase
      for (genvar bi = 0; bi < HALF; bi++) begin : g_row
         for (genvar bj = 0; bj < HALF; bj++) begin : g_col
            localparam int unsigned R0 = (2 * bi + p) % SIDE;
            localparam int unsigned R1 = (2 * bi + p + 1) % SIDE;
            localparam int unsigned C0 = (2 * bj + p) % SIDE;
            localparam int unsigned C1 = (2 * bj + p + 1) % SIDE;
            quad_t q_in;
            quad_t q_out;

            assign q_in = {cur[R1*SIDE+C1], cur[R1*SIDE+C0],
                           cur[R0*SIDE+C1], cur[R0*SIDE+C0]};

            mbca_block_rule u_rule (
               .cur (q_in),
               .nxt (q_out)
            );

            assign cand[p][R0*SIDE+C0] = q_out[0];
            assign cand[p][R0*SIDE+C1] = q_out[1];
            assign cand[p][R1*SIDE+C0] = q_out[2];
            assign cand[p][R1*SIDE+C1] = q_out[3];
         end
      end
   end

   assign nxt = (rule_phase == PH_ODD) ? cand[1] : cand[0];

endmodule

// File: rtl/mbca_step_ctrl.sv
module mbca_step_ctrl
   import mbca_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             reverse,
   output logic             advance,
   output logic             rule_phase,
   output logic             phase,
   output logic [CNT_W-1:0] count
);

   phase_e ph_q;

   assign advance    = step && !load;
   // backward: undo the toggle first, then apply the rule with that phase
   assign rule_phase = reverse ? ~ph_q : ph_q;
   assign phase      = ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_EVEN;
         count <= '0;
      end else if (load) begin
         ph_q  <= PH_EVEN;
         count <= '0;
      end else if (step) begin
         ph_q  <= phase_e'(~ph_q);
         count <= reverse ? count - 1'b1 : count + 1'b1;
      end
   end

   a_r5_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (phase != $past(phase)));

   a_r7_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !reverse) |=> (count == $past(count) + 1'b1));

   a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && reverse) |=> (count == $past(count) - 1'b1));

   a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == '0 && phase == 1'b0));

endmodule

// File: rtl/mbca_lattice_engine.sv
module mbca_lattice_engine
   import mbca_pkg::*;
#(
   parameter int unsigned SIDE  = 10,
   parameter int unsigned CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [SIDE*SIDE-1:0] load_pattern,
   input  logic                 step,
   input  logic                 reverse,
   output logic [SIDE*SIDE-1:0] cells,
   output logic [CNT_W-1:0]     step_count,
   output logic                 phase
);

   localparam int unsigned CELLS = SIDE * SIDE;

   if (SIDE < 4 || (SIDE % 2) != 0) begin : g_bad_side
      $error("SIDE must be even and at least 4");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic             advance;
   logic             rule_phase;
   logic [CELLS-1:0] next_cells;

   mbca_step_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .step       (step),
      .reverse    (reverse),
      .advance    (advance),
      .rule_phase (rule_phase),
      .phase      (phase),
      .count      (step_count)
   );

   mbca_lattice_step #(.SIDE(SIDE)) u_step (
      .cur        (cells),
      .rule_phase (rule_phase),
      .nxt        (next_cells)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cells <= '0;
      else if (load)    cells <= load_pattern;
      else if (advance) cells <= next_cells;
   end

   a_r6_particles_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> ($countones(cells) == $past($countones(cells))));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> ($stable(cells) && $stable(step_count) && $stable(phase)));

   a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cells == $past(load_pattern)));

endmodule

// File: tb/mbca_lattice_engine_test.sv
module mbca_lattice_engine_test;

   localparam int SIDE  = 10;
   localparam int CELLS = SIDE * SIDE;
   localparam int CNT_W = 16;

   // fields: a, b, expect(3,6), expect(6,3), expect(6,6), expect(3,3)
   localparam logic [5:0] GATE_VEC [4] = '{
      6'b00_0000,
      6'b10_0010,
      6'b01_0001,
      6'b11_1100
   };

   logic             clk = 0;
   logic             rst_n = 0;
   logic             load = 0;
   logic [CELLS-1:0] load_pattern = '0;
   logic             step = 0;
   logic             reverse = 0;
   logic [CELLS-1:0] cells;
   logic [CNT_W-1:0] step_count;
   logic             phase;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   mbca_lattice_engine #(.SIDE(SIDE), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .load(load), .load_pattern(load_pattern),
      .step(step), .reverse(reverse), .cells(cells),
      .step_count(step_count), .phase(phase)
   );

   function automatic int ix(int r, int c);
      return r * SIDE + c;
   endfunction

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_load(logic [CELLS-1:0] pat);
      @(negedge clk);
      load = 1; load_pattern = pat;
      @(negedge clk);
      load = 0;
   endtask

   task automatic do_steps(int n, logic rev);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         step = 1; reverse = rev;
      end
      @(negedge clk);
      step = 0; reverse = 0;
   endtask

   logic [CELLS-1:0] pat, exp_lat;

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 lattice", cells, 0);
      chk("R1 count", step_count, 0);
      chk("R1 phase", phase, 0);
      rst_n = 1;

      // R9 gate table, followed by R8 round trip
      foreach (GATE_VEC[k]) begin
         pat = '0;
         pat[ix(2,2)] = GATE_VEC[k][5];
         pat[ix(7,7)] = GATE_VEC[k][4];
         do_load(pat);
         do_steps(4, 1'b0);
         chk("R9 cell(3,6)", cells[ix(3,6)], GATE_VEC[k][3]);
         chk("R9 cell(6,3)", cells[ix(6,3)], GATE_VEC[k][2]);
         chk("R9 cell(6,6)", cells[ix(6,6)], GATE_VEC[k][1]);
         chk("R9 cell(3,3)", cells[ix(3,3)], GATE_VEC[k][0]);
         chk("R6 population", $countones(cells), $countones(pat));
         chk("R7 count after 4 fwd", step_count, 4);
         do_steps(4, 1'b1);
         chk("R8 restored", cells, pat);
         chk("R7 count after 4 back", step_count, 0);
      end

      // R3 lone particle and R5 wrap: (1,1)->(0,0)->(9,9)->(8,8)
      pat = '0; pat[ix(1,1)] = 1;
      do_load(pat);
      do_steps(1, 1'b0);
      exp_lat = '0; exp_lat[ix(0,0)] = 1;
      chk("R3 lone particle half-turn", cells, exp_lat);
      chk("R5 phase after one step", phase, 1);
      do_steps(1, 1'b0);
      exp_lat = '0; exp_lat[ix(9,9)] = 1;
      chk("R5 odd tiling wraps", cells, exp_lat);
      do_steps(1, 1'b0);
      exp_lat = '0; exp_lat[ix(8,8)] = 1;
      chk("R5 even tiling", cells, exp_lat);

      // R4 diagonal pair swaps diagonals
      pat = '0; pat[ix(0,0)] = 1; pat[ix(1,1)] = 1;
      do_load(pat);
      do_steps(1, 1'b0);
      exp_lat = '0; exp_lat[ix(0,1)] = 1; exp_lat[ix(1,0)] = 1;
      chk("R4 main to anti diagonal", cells, exp_lat);
      do_steps(1, 1'b1);
      chk("R4 back to main diagonal", cells, pat);

      // R3 three particles half-turn
      pat = '0; pat[ix(0,0)] = 1; pat[ix(0,1)] = 1; pat[ix(1,0)] = 1;
      do_load(pat);
      do_steps(1, 1'b0);
      exp_lat = '0; exp_lat[ix(1,1)] = 1; exp_lat[ix(1,0)] = 1; exp_lat[ix(0,1)] = 1;
      chk("R3 three particles", cells, exp_lat);

      // R7/R8 backward from load wraps count, forward restores
      pat = '0; pat[ix(4,7)] = 1; pat[ix(5,2)] = 1; pat[ix(9,0)] = 1;
      do_load(pat);
      do_steps(1, 1'b1);
      chk("R7 count wraps below zero", step_count, 16'hFFFF);
      chk("R5 phase after back step", phase, 1);
      do_steps(1, 1'b0);
      chk("R8 back then forward", cells, pat);
      chk("R7 count back to zero", step_count, 0);

      // R10 idle hold
      do_steps(3, 1'b0);
      exp_lat = cells;
      repeat (5) @(negedge clk);
      chk("R10 lattice held", cells, exp_lat);
      chk("R10 count held", step_count, 3);

      // R2 load wins over step
      pat = '0; pat[ix(6,6)] = 1;
      @(negedge clk);
      load = 1; step = 1; load_pattern = pat;
      @(negedge clk);
      load = 0; step = 0;
      chk("R2 load priority lattice", cells, pat);
      chk("R2 load priority count", step_count, 0);
      chk("R2 load priority phase", phase, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule